// File: doc/BRIEF.md
# Bus Address Translation Window Bank

This block holds the programmable translation windows of a host-to-PCI bridge. Software programs each window through 32-bit registers in a 1 KB register page. Each window has a target page number, a base page number, an extension word and an attribute word. The block keeps the register state and offers two combinational lookup ports. The outbound port maps CPU-side addresses to PCI bus addresses. The inbound port maps PCI-side addresses to local memory addresses.

Base and target registers hold 4 KB page numbers, so a byte address is the register value followed by twelve zero bits. The low six attribute bits give the window size as two shifted left by that field. Attribute bit 31 enables the window. Each lookup port returns a hit flag, the number of the winning window and the translated address. A register write affects the lookups from the next clock cycle.

Top module: `xlate_windows`

## Requirements
- R1: After reset every register reads zero and both lookup ports report a miss.
- R2: The outbound register groups sit at page offsets 0x020, 0x040, 0x060 and 0x080, and each is numbered by address bits [7:5] (1 to 4). Inside a group, offset 0x10 holds the attributes, 0x8 the base page, 0x4 the target extension and 0x0 the target page. A written value reads back unchanged.
- R3: The inbound register groups sit at 0x1A0, 0x1C0 and 0x1E0, and each is numbered by address bits [6:5] minus one (0 to 2). Inside a group, offset 0x0 holds the target page, 0x8 the base page, 0xC the base extension and 0x10 the attributes. A written value reads back unchanged.
- R4: One scratch timer register answers at every offset from 0x220 to 0x23F, is readable and writable, and has no effect on either lookup.
- R5: Reads of any other offset return zero, and writes to them change no register and no lookup result. This covers group 0x000, groups past 0x080, and unlisted offsets inside a window group.
- R6: A window hits when attribute bit 31 is set and base*4096 <= address < base*4096 + (2 << attribute[5:0]).
- R7: The translated address is target*4096 + (address - base*4096), taken modulo 2^44.
- R8: When several outbound windows hit, the lowest-numbered one wins, and its number (1 to 4) is reported.
- R9: When several inbound windows hit, the lowest-numbered one wins, and its number (0 to 2) is reported.
- R10: On a miss, the hit flag, the window number and the translated address are all zero.
- R11: A write to any window register takes effect on the lookups from the next cycle. Clearing the enable bit removes the window at once.
- R12: The extension registers are stored and read back, but they do not change translation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 10 | Byte offset within the register page |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data for regAddr (combinational) |
| obAddr | input | 44 | CPU-side address to translate |
| obHit | output | 1 | An outbound window matched |
| obIdx | output | 3 | Winning outbound window number |
| obXlated | output | 44 | Resulting PCI bus address |
| ibAddr | input | 44 | PCI-side address to translate |
| ibHit | output | 1 | An inbound window matched |
| ibIdx | output | 2 | Winning inbound window number |
| ibXlated | output | 44 | Resulting local memory address |

## Verification
Some properties are checked on every cycle: the reported window number stays in range on a hit, a miss drives all-zero results, undecoded offsets read zero, and a decoded write reads back on the next cycle. Other behaviours can only be shown by the bench's scenarios. These are the window limits at both edges, lowest-number priority between overlapping windows, translation arithmetic, the timer and the extension words having no effect on lookups, and writes to undecoded offsets leaving every window untouched. The bench covers them with directed corner cases and seeded random programming checked against a reference model.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  parameter int REG_W      = 32;
  parameter int PAGE_SHIFT = 12;
  parameter int ADDR_W     = REG_W + PAGE_SHIFT;
  parameter int OB_WINS    = 4;
  parameter int IB_WINS    = 3;
  parameter int OB_IDX_W   = $clog2(OB_WINS + 1);
  parameter int IB_IDX_W   = $clog2(IB_WINS);
  parameter int SLOT_W     = 3;
  parameter int EN_BIT     = 31;
  parameter int SZ_W       = 6;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_TGT,
    FLD_EXT,
    FLD_BASE,
    FLD_ATTR
  } fld_e;

  // decode result handed from control to datapath
  typedef struct packed {
    logic              wr;
    logic              isOb;
    logic              isIb;
    logic              isTmr;
    logic [SLOT_W-1:0] slot;
    fld_e              fld;
  } regStrobe_t;

  typedef struct packed {
    logic [REG_W-1:0] tgt;
    logic [REG_W-1:0] ext;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] attr;
  } winRegs_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int PAGE_AW = 10,
  parameter int GRP_LSB = 5,
  parameter int OB_GRP0 = 1,
  parameter int IB_GRP0 = 13,
  parameter int TMR_GRP = 17
) (
  input  logic [PAGE_AW-1:0] regAddr,
  input  logic               regWr,
  output regStrobe_t         strobe
);
  localparam int GRP_W = PAGE_AW - GRP_LSB;
  localparam logic [GRP_W-1:0] OB_FIRST = GRP_W'(OB_GRP0);
  localparam logic [GRP_W-1:0] OB_LAST  = GRP_W'(OB_GRP0 + OB_WINS - 1);
  localparam logic [GRP_W-1:0] IB_FIRST = GRP_W'(IB_GRP0);
  localparam logic [GRP_W-1:0] IB_LAST  = GRP_W'(IB_GRP0 + IB_WINS - 1);
  localparam logic [GRP_W-1:0] TMR_G    = GRP_W'(TMR_GRP);
  localparam logic [GRP_LSB-1:0] OFS_0  = GRP_LSB'(0);
  localparam logic [GRP_LSB-1:0] OFS_4  = GRP_LSB'(4);
  localparam logic [GRP_LSB-1:0] OFS_8  = GRP_LSB'(8);
  localparam logic [GRP_LSB-1:0] OFS_C  = GRP_LSB'(12);
  localparam logic [GRP_LSB-1:0] OFS_10 = GRP_LSB'(16);

  logic [GRP_W-1:0]   grp;
  logic [GRP_LSB-1:0] off;

  assign grp = regAddr[PAGE_AW-1:GRP_LSB];
  assign off = regAddr[GRP_LSB-1:0];

  always_comb begin
    strobe     = '0;
    strobe.fld = FLD_NONE;
    strobe.wr  = regWr;
    if (grp >= OB_FIRST && grp <= OB_LAST) begin
      strobe.isOb = 1'b1;
      strobe.slot = SLOT_W'(grp - OB_FIRST);
      unique case (off)
        OFS_0:   strobe.fld = FLD_TGT;
        OFS_4:   strobe.fld = FLD_EXT;
        OFS_8:   strobe.fld = FLD_BASE;
        OFS_10:  strobe.fld = FLD_ATTR;
        default: strobe.fld = FLD_NONE;
      endcase
    end else if (grp >= IB_FIRST && grp <= IB_LAST) begin
      strobe.isIb = 1'b1;
      strobe.slot = SLOT_W'(grp - IB_FIRST);
      unique case (off)
        OFS_0:   strobe.fld = FLD_TGT;
        OFS_8:   strobe.fld = FLD_BASE;
        OFS_C:   strobe.fld = FLD_EXT;
        OFS_10:  strobe.fld = FLD_ATTR;
        default: strobe.fld = FLD_NONE;
      endcase
    end else if (grp == TMR_G) begin
      strobe.isTmr = 1'b1;
    end
  end
endmodule

// File: rtl/xlate_regs.sv
module xlate_regs
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [REG_W-1:0] wData,
  output logic [REG_W-1:0] rData,
  output winRegs_t         obWins [OB_WINS],
  output winRegs_t         ibWins [IB_WINS]
);
  logic [REG_W-1:0] tmrReg;

  for (genvar i = 0; i < OB_WINS; i++) begin : g_ob
    winRegs_t r;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        r <= '0;
      end else if (strobe.wr && strobe.isOb && strobe.slot == SLOT_W'(i)) begin
        case (strobe.fld)
          FLD_TGT:  r.tgt  <= wData;
          FLD_EXT:  r.ext  <= wData;
          FLD_BASE: r.base <= wData;
          FLD_ATTR: r.attr <= wData;
          default:  ;
        endcase
      end
    end
    assign obWins[i] = r;
  end

  for (genvar i = 0; i < IB_WINS; i++) begin : g_ib
    winRegs_t r;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        r <= '0;
      end else if (strobe.wr && strobe.isIb && strobe.slot == SLOT_W'(i)) begin
        case (strobe.fld)
          FLD_TGT:  r.tgt  <= wData;
          FLD_EXT:  r.ext  <= wData;
          FLD_BASE: r.base <= wData;
          FLD_ATTR: r.attr <= wData;
          default:  ;
        endcase
      end
    end
    assign ibWins[i] = r;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         tmrReg <= '0;
    else if (strobe.wr && strobe.isTmr) tmrReg <= wData;
  end

  winRegs_t sel;
  always_comb begin
    sel = '0;
    for (int i = 0; i < OB_WINS; i++)
      if (strobe.isOb && strobe.slot == SLOT_W'(i)) sel = obWins[i];
    for (int i = 0; i < IB_WINS; i++)
      if (strobe.isIb && strobe.slot == SLOT_W'(i)) sel = ibWins[i];
    rData = '0;
    if (strobe.isTmr) begin
      rData = tmrReg;
    end else begin
      case (strobe.fld)
        FLD_TGT:  rData = sel.tgt;
        FLD_EXT:  rData = sel.ext;
        FLD_BASE: rData = sel.base;
        FLD_ATTR: rData = sel.attr;
        default:  rData = '0;
      endcase
    end
  end
endmodule

// File: rtl/xlate_lookup.sv
module xlate_lookup
  import xlate_pkg::*;
#(
  parameter int N        = 4,
  parameter int IDX_W    = 3,
  parameter int IDX_BASE = 1
) (
  input  winRegs_t          wins [N],
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] xlated
);
  localparam int LIM_W = (1 << SZ_W) + 2;

  logic [N-1:0]      match;
  logic [ADDR_W-1:0] xl [N];

  for (genvar i = 0; i < N; i++) begin : g_win
    logic [ADDR_W-1:0] baseB;
    logic [ADDR_W-1:0] tgtB;
    logic [ADDR_W-1:0] ofs;
    logic [LIM_W-1:0]  lim;
    logic              unusedBits;

    assign baseB      = {wins[i].base, {PAGE_SHIFT{1'b0}}};
    assign tgtB       = {wins[i].tgt, {PAGE_SHIFT{1'b0}}};
    assign ofs        = addr - baseB;
    assign lim        = LIM_W'(2) << wins[i].attr[SZ_W-1:0];
    assign match[i]   = wins[i].attr[EN_BIT] && (addr >= baseB) && (LIM_W'(ofs) < lim);
    assign xl[i]      = tgtB + ofs;
    assign unusedBits = ^{wins[i].ext, wins[i].attr[EN_BIT-1:SZ_W]};
  end

  // scan downward so the lowest-numbered hit is written last
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    xlated = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit    = 1'b1;
        idx    = IDX_W'(i + IDX_BASE);
        xlated = xl[i];
      end
    end
  end
endmodule

// File: rtl/xlate_windows.sv
module xlate_windows
  import xlate_pkg::*;
#(
  parameter int PAGE_AW = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [PAGE_AW-1:0]  regAddr,
  input  logic [REG_W-1:0]    regWData,
  output logic [REG_W-1:0]    regRData,
  input  logic [ADDR_W-1:0]   obAddr,
  output logic                obHit,
  output logic [OB_IDX_W-1:0] obIdx,
  output logic [ADDR_W-1:0]   obXlated,
  input  logic [ADDR_W-1:0]   ibAddr,
  output logic                ibHit,
  output logic [IB_IDX_W-1:0] ibIdx,
  output logic [ADDR_W-1:0]   ibXlated
);
  regStrobe_t strobe;
  winRegs_t   obWins [OB_WINS];
  winRegs_t   ibWins [IB_WINS];

  xlate_ctrl #(.PAGE_AW(PAGE_AW)) ctrl_i (
    .regAddr (regAddr),
    .regWr   (regWr),
    .strobe  (strobe)
  );

  xlate_regs regs_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wData  (regWData),
    .rData  (regRData),
    .obWins (obWins),
    .ibWins (ibWins)
  );

  xlate_lookup #(.N(OB_WINS), .IDX_W(OB_IDX_W), .IDX_BASE(1)) obLook_i (
    .wins   (obWins),
    .addr   (obAddr),
    .hit    (obHit),
    .idx    (obIdx),
    .xlated (obXlated)
  );

  xlate_lookup #(.N(IB_WINS), .IDX_W(IB_IDX_W), .IDX_BASE(0)) ibLook_i (
    .wins   (ibWins),
    .addr   (ibAddr),
    .hit    (ibHit),
    .idx    (ibIdx),
    .xlated (ibXlated)
  );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk
  import xlate_pkg::*;
#(
  parameter int PAGE_AW = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWr,
  input logic [PAGE_AW-1:0]  regAddr,
  input logic [REG_W-1:0]    regWData,
  input logic [REG_W-1:0]    regRData,
  input logic                obHit,
  input logic [OB_IDX_W-1:0] obIdx,
  input logic [ADDR_W-1:0]   obXlated,
  input logic                ibHit,
  input logic [IB_IDX_W-1:0] ibIdx,
  input logic [ADDR_W-1:0]   ibXlated
);
  localparam int GW = PAGE_AW - 5;
  logic [GW-1:0] g;
  logic [4:0]    o;
  logic          obOfs, ibOfs, decodable;

  assign g         = regAddr[PAGE_AW-1:5];
  assign o         = regAddr[4:0];
  assign obOfs     = (o == 5'h00) || (o == 5'h04) || (o == 5'h08) || (o == 5'h10);
  assign ibOfs     = (o == 5'h00) || (o == 5'h08) || (o == 5'h0C) || (o == 5'h10);
  assign decodable = (g >= GW'(1) && g <= GW'(OB_WINS) && obOfs) ||
                     (g >= GW'(13) && g <= GW'(12 + IB_WINS) && ibOfs) ||
                     (g == GW'(17));

  // R8
  ob_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    obHit |-> (obIdx >= OB_IDX_W'(1) && obIdx <= OB_IDX_W'(OB_WINS)));

  // R9
  ib_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ibHit |-> (ibIdx <= IB_IDX_W'(IB_WINS - 1)));

  // R10
  ob_miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !obHit |-> (obIdx == '0 && obXlated == '0));

  // R10
  ib_miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ibHit |-> (ibIdx == '0 && ibXlated == '0));

  // R5
  undecoded_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decodable |-> (regRData == '0));

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && decodable) |=> ($stable(regAddr) |-> (regRData == $past(regWData))));
endmodule

bind xlate_windows xlate_chk #(.PAGE_AW(PAGE_AW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWData (regWData),
  .regRData (regRData),
  .obHit    (obHit),
  .obIdx    (obIdx),
  .obXlated (obXlated),
  .ibHit    (ibHit),
  .ibIdx    (ibIdx),
  .ibXlated (ibXlated)
);

// File: tb/xlate_windows_tb.sv
module xlate_windows_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [9:0]  regAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic [43:0] obAddr = '0;
  logic        obHit;
  logic [2:0]  obIdx;
  logic [43:0] obXlated;
  logic [43:0] ibAddr = '0;
  logic        ibHit;
  logic [1:0]  ibIdx;
  logic [43:0] ibXlated;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;

  // model: field 0 target, 1 extension, 2 base, 3 attributes
  logic [31:0] mOb [4][4];
  logic [31:0] mIb [3][4];
  logic [31:0] mTmr;

  always #5 clk = ~clk;

  xlate_windows dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData),
    .obAddr(obAddr), .obHit(obHit), .obIdx(obIdx), .obXlated(obXlated),
    .ibAddr(ibAddr), .ibHit(ibHit), .ibIdx(ibIdx), .ibXlated(ibXlated)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nBad++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int fldOf(input bit ob, input int o);
    if (o == 0) return 0;
    if (o == 8) return 2;
    if (o == 16) return 3;
    if (ob && o == 4) return 1;
    if (!ob && o == 12) return 1;
    return -1;
  endfunction

  function automatic logic [31:0] modelRd(input logic [9:0] a);
    int g = int'(a[9:5]);
    int f;
    if (g >= 1 && g <= 4) begin
      f = fldOf(1'b1, int'(a[4:0]));
      if (f >= 0) return mOb[g-1][f];
    end else if (g >= 13 && g <= 15) begin
      f = fldOf(1'b0, int'(a[4:0]));
      if (f >= 0) return mIb[g-13][f];
    end else if (g == 17) return mTmr;
    return '0;
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    int g = int'(a[9:5]);
    int f;
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWr = 1'b0;
    if (g >= 1 && g <= 4) begin
      f = fldOf(1'b1, int'(a[4:0]));
      if (f >= 0) mOb[g-1][f] = d;
    end else if (g >= 13 && g <= 15) begin
      f = fldOf(1'b0, int'(a[4:0]));
      if (f >= 0) mIb[g-13][f] = d;
    end else if (g == 17) mTmr = d;
  endtask

  task automatic rdChk(input string req, input logic [9:0] a);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, 64'(regRData), 64'(modelRd(a)));
  endtask

  function automatic logic [47:0] expLook(input bit ob, input logic [43:0] a);
    int n = ob ? 4 : 3;
    for (int i = 0; i < n; i++) begin
      logic [31:0] at = ob ? mOb[i][3] : mIb[i][3];
      logic [43:0] b  = {(ob ? mOb[i][2] : mIb[i][2]), 12'h000};
      logic [43:0] t  = {(ob ? mOb[i][0] : mIb[i][0]), 12'h000};
      logic [65:0] lim = 66'd2 << at[5:0];
      if (at[31] && a >= b && {22'b0, a - b} < lim)
        return {1'b1, 3'(ob ? i + 1 : i), t + (a - b)};
    end
    return '0;
  endfunction

  task automatic obChk(input string req, input logic [43:0] a);
    @(negedge clk);
    obAddr = a;
    #1;
    chk(req, 64'({obHit, obIdx, obXlated}), 64'(expLook(1'b1, a)));
  endtask

  task automatic ibChk(input string req, input logic [43:0] a);
    @(negedge clk);
    ibAddr = a;
    #1;
    chk(req, 64'({ibHit, 1'b0, ibIdx, ibXlated}), 64'(expLook(1'b0, a)));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4; i++) for (int f = 0; f < 4; f++) mOb[i][f] = '0;
    for (int i = 0; i < 3; i++) for (int f = 0; f < 4; f++) mIb[i][f] = '0;
    mTmr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rdChk("R1 ob attr", 10'h030);
    rdChk("R1 ib base", 10'h1C8);
    rdChk("R1 timer", 10'h220);
    obChk("R1 ob miss", 44'h0);
    ibChk("R1 ib miss", 44'h0);

    // R2 / R11: program outbound slot 1, enable last
    wr(10'h020, 32'h0008_0000);
    wr(10'h028, 32'h0001_0000);
    rdChk("R2 ob target", 10'h020);
    rdChk("R2 ob base", 10'h028);
    obChk("R11 not yet enabled", 44'h0_1000_0123);
    wr(10'h030, 32'h8000_000B);
    rdChk("R2 ob attr", 10'h030);
    obChk("R7 ob translate", 44'h0_1000_0123);
    obChk("R6 top edge hit", 44'h0_1000_0FFF);
    obChk("R6 past top miss", 44'h0_1000_1000);
    obChk("R6 below base miss", 44'h0_0FFF_FFFF);

    // R12: extension word stored, no effect
    wr(10'h024, 32'hDEAD_BEEF);
    rdChk("R12 ob ext readback", 10'h024);
    obChk("R12 ob ext no effect", 44'h0_1000_0040);

    // R8: slot 3 overlaps with larger window
    wr(10'h060, 32'h0009_0000);
    wr(10'h068, 32'h0001_0000);
    wr(10'h070, 32'h8000_000F);
    obChk("R8 lowest slot wins", 44'h0_1000_0200);
    obChk("R8 slot 3 alone", 44'h0_1000_2200);
    wr(10'h030, 32'h0000_000B);
    obChk("R11 disable removes", 44'h0_1000_0200);
    wr(10'h080, 32'h1234_5678);
    rdChk("R2 slot 4 target", 10'h080);

    // R3: inbound, index 2 at 0x1E0
    wr(10'h1E0, 32'h0000_0400);
    wr(10'h1E8, 32'h0000_0020);
    wr(10'h1EC, 32'h0000_0055);
    wr(10'h1F0, 32'h8000_000C);
    rdChk("R3 ib ext readback", 10'h1EC);
    ibChk("R3 ib index 2", 44'h0_0002_1ABC);
    wr(10'h1A0, 32'h0000_0700);
    wr(10'h1A8, 32'h0000_0020);
    wr(10'h1B0, 32'h8000_000B);
    ibChk("R9 ib lowest wins", 44'h0_0002_0010);
    ibChk("R9 ib other window", 44'h0_0002_1010);

    // R6 size field extremes
    wr(10'h1D0, 32'h8000_003F);
    ibChk("R6 full-space window", 44'hF_FFFF_FFFF);
    wr(10'h1D0, 32'h8000_0000);
    wr(10'h1C8, 32'h0000_0900);
    ibChk("R6 two-byte window hit", 44'h0_0090_0001);
    ibChk("R6 two-byte window miss", 44'h0_0090_0002);

    // R4: timer aliases across its group, no lookup effect
    wr(10'h23C, 32'hCAFE_F00D);
    rdChk("R4 timer read", 10'h220);
    chk("R4 timer alias", 64'(regRData), 64'h0000_0000_CAFE_F00D);
    obChk("R4 timer no effect", 44'h0_1000_2200);

    // R5: undecoded offsets
    wr(10'h000, 32'hFFFF_FFFF);
    wr(10'h010, 32'h8000_0030);
    wr(10'h02C, 32'h8000_0030);
    wr(10'h0A0, 32'hFFFF_FFFF);
    wr(10'h1A4, 32'hFFFF_FFFF);
    wr(10'h300, 32'hFFFF_FFFF);
    rdChk("R5 group 0 reads zero", 10'h010);
    rdChk("R5 ob odd offset zero", 10'h02C);
    rdChk("R5 ib odd offset zero", 10'h1A4);
    rdChk("R5 high page zero", 10'h300);
    obChk("R5 no new window", 44'h0_0000_0100);
    rdChk("R5 slot 1 attr intact", 10'h030);

    // random programming mixed with lookups (R6 R7 R8 R9 R11)
    for (int it = 0; it < 400; it++) begin
      int sel = int'($urandom_range(0, 6));
      int w;
      logic [9:0] a;
      if (sel < 4) begin
        w = int'($urandom_range(0, 3));
        case ($urandom_range(0, 3))
          0: a = 10'((w + 1) * 32 + 0);
          1: a = 10'((w + 1) * 32 + 8);
          2: a = 10'((w + 1) * 32 + 16);
          default: a = 10'((w + 1) * 32 + 4);
        endcase
      end else begin
        w = int'($urandom_range(0, 2));
        case ($urandom_range(0, 3))
          0: a = 10'((w + 13) * 32 + 0);
          1: a = 10'((w + 13) * 32 + 8);
          2: a = 10'((w + 13) * 32 + 16);
          default: a = 10'((w + 13) * 32 + 12);
        endcase
      end
      if (a[4:0] == 5'h10)
        wr(a, {$urandom_range(0, 3) != 0, 25'h0, 6'($urandom_range(11, 20))});
      else if (a[4:0] == 5'h08)
        wr(a, 32'($urandom_range(0, 1023)));
      else
        wr(a, $urandom());
      rdChk("R2 R3 random readback", a);
      for (int k = 0; k < 3; k++) begin
        logic [43:0] la = {12'h0, 10'($urandom_range(0, 1023)), 22'($urandom())} >> 10;
        obChk("R6 R7 R8 random ob", la);
        ibChk("R6 R7 R9 random ib", la);
      end
    end

    summary();
  end
endmodule